// File: doc/BRIEF.md
# SPI Register Bank Slave with Burst Auto-Increment

This block lets an external SPI master read and write a bank of 128 eight-bit registers. Each transaction starts when chip select goes low. The first byte is a command: its top bit selects the direction (1 for write, 0 for read) and its lower seven bits give the starting register address. Any number of data bytes follow.

After each complete data byte the address steps to the next register, so a master can stream a whole range of registers while chip select stays low without sending the address again. The serial pins are sampled in the system clock domain. SCK is treated as data and is never used as a clock. A combinational inspection port lets the surrounding logic read any register at any time.

Top module: `spi_regbank`

## Requirements
- R1: After reset every register reads 0x00 on the inspection port and MISO is low.
- R2: The first bit clocked in after chip select falls is the direction flag (1 = write, 0 = read). The next seven bits are the register address, most significant bit first.
- R3: In a write, each data byte is taken MSB first and is stored in the addressed register once its eighth bit has been received.
- R4: In a write burst, the address advances by one after every complete data byte, so byte k of the burst lands in register start+k.
- R5: Mode 0 timing applies: MOSI is sampled on the SCK rising edge and MISO changes after the SCK falling edge. In a read, the MSB of the addressed register is valid on MISO at the first rising edge after the command byte, and the remaining bits follow MSB first.
- R6: In a read burst, data byte k returns register start+k.
- R7: The burst address wraps from 0x7F to 0x00 for both reads and writes.
- R8: Raising chip select in the middle of a byte discards the partial byte without writing it. The next transaction starts again with a command byte.
- R9: MISO is low whenever chip select is high.
- R10: The inspection port returns the current content of the register it selects, combinationally.
- R11: SCK and MOSI activity while chip select is high changes no register and does not disturb the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the master |
| peek_addr | input | 7 | Register selected by the inspection port |
| peek_data | output | 8 | Content of the selected register |

## Verification
The assertions assume that SCK high and low phases each last several system clocks, and that MOSI and chip select only change while SCK is low. Under those conditions the synchronized edges arrive in order and never coincide.

The bench drives SCK with phases of eight system clocks. It changes MOSI only in the low phase and moves chip select only with SCK low and at least one phase away from any edge. Within those limits it sweeps every register address in both directions, across the wrap point, with aborted bytes and with idle clocking.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          cs_n,
  output logic          miso,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data
);
  localparam int NREG = 1 << AW;
  localparam int CW   = $clog2(DW);

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire active = ~cs_q[1];
  wire rise   = active & sck_q[1] & ~sck_q[2];
  wire fall   = active & ~sck_q[1] & sck_q[2];
  wire cs_end = cs_q[1] & ~cs_q[2];

  logic [DW-1:0] regs [NREG];
  logic [CW-1:0] bcnt;
  logic          in_cmd, wr_mode;
  logic [AW-1:0] addr;
  logic [DW-1:0] sh_in, sh_out;

  wire [DW-1:0] rx_byte   = {sh_in[DW-2:0], mosi_q[1]};
  wire          byte_done = rise && (bcnt == CW'(DW-1));
  wire          load_rd   = fall && !in_cmd && (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      bcnt    <= '0;
      in_cmd  <= 1'b1;
      wr_mode <= 1'b0;
      addr    <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
    end else if (!active) begin
      bcnt   <= '0;
      in_cmd <= 1'b1;
      sh_out <= '0;
    end else begin
      if (rise) begin
        sh_in <= rx_byte;
        bcnt  <= byte_done ? '0 : bcnt + 1'b1;
        if (byte_done) begin
          if (in_cmd) begin
            in_cmd  <= 1'b0;
            wr_mode <= rx_byte[DW-1];
            addr    <= rx_byte[AW-1:0];
          end else begin
            if (wr_mode) regs[addr] <= rx_byte;
            addr <= addr + 1'b1;
          end
        end
      end
      if (fall) sh_out <= load_rd ? regs[addr] : {sh_out[DW-2:0], 1'b0};
    end

  assign miso      = active & sh_out[DW-1];
  assign peek_data = regs[peek_addr];

  // R2
  cmd_parse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && in_cmd |=> !in_cmd && addr == $past(rx_byte[AW-1:0]));

  // R3
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !in_cmd && wr_mode |=> regs[$past(addr)] == $past(rx_byte));

  // R7
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !in_cmd && addr == {AW{1'b1}} |=> addr == '0);

  // R5
  read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rd |=> sh_out == $past(regs[addr]));

  // R8
  abort_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> bcnt == '0 && in_cmd);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[2] && cs_q[1] |-> sh_out == '0 && !miso);
endmodule

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  localparam int HALF = 40;

  logic clk = 0, rst_n = 0, sck = 0, mosi = 0, cs_n = 1;
  logic miso;
  logic [6:0] peek_addr = '0;
  logic [7:0] peek_data;
  logic [7:0] model [128];
  int vectors = 0, errors = 0;

  spi_regbank uut (.clk, .rst_n, .sck, .mosi, .cs_n, .miso, .peek_addr, .peek_data);

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #HALF;
      rx[i] = miso;
      sck = 1;
      #HALF;
      sck = 0;
    end
  endtask

  task automatic start_txn();
    cs_n = 0;
    #HALF;
  endtask

  task automatic end_txn();
    #HALF;
    cs_n = 1;
    #(4*HALF);
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  // R3 R4 R7
  task automatic wr_burst(input int start, input int n, input int seed);
    logic [7:0] rx;
    start_txn();
    xfer({1'b1, 7'(start)}, rx);
    for (int k = 0; k < n; k++) begin
      xfer(pat((start + k) & 127, seed), rx);
      model[(start + k) & 127] = pat((start + k) & 127, seed);
    end
    end_txn();
  endtask

  // R5 R6 R7
  task automatic rd_burst(input int start, input int n, input string req);
    logic [7:0] rx;
    start_txn();
    xfer({1'b0, 7'(start)}, rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx);
      check(rx === model[(start + k) & 127], req, rx, model[(start + k) & 127]);
    end
    end_txn();
  endtask

  // R10
  task automatic peek_all(input string req);
    for (int a = 0; a < 128; a++) begin
      peek_addr = 7'(a);
      #1;
      check(peek_data === model[a], req, peek_data, model[a]);
    end
  endtask

  initial begin
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    #23 rst_n = 1;
    #20;
    // R1
    check(miso === 1'b0, "R1 miso", miso, 0);
    peek_all("R1 reset");

    // R2 R3 R4 R10: full write burst
    wr_burst(0, 128, 1);
    peek_all("R4 burst write");
    // R9
    check(miso === 1'b0, "R9 idle miso", miso, 0);

    // R5 R6: full read burst
    rd_burst(0, 128, "R6 burst read");
    check(miso === 1'b0, "R9 miso after read", miso, 0);

    // R7 wrap on write and read
    wr_burst(126, 4, 2);
    peek_all("R7 wrap write");
    rd_burst(127, 3, "R7 wrap read");

    // R2 single-register accesses at scattered addresses
    for (int a = 3; a < 128; a += 29) begin
      wr_burst(a, 1, 3);
      rd_burst(a, 1, "R2 single");
    end
    peek_all("R3 single writes");

    // R8 partial byte discarded
    begin
      logic [7:0] rx;
      start_txn();
      xfer(8'h85, rx);
      for (int i = 0; i < 4; i++) begin
        mosi = 1;
        #HALF;
        sck = 1;
        #HALF;
        sck = 0;
      end
      end_txn();
    end
    peek_all("R8 partial discard");
    rd_burst(5, 2, "R8 next txn");

    // R11 clocking with chip select high
    for (int i = 0; i < 24; i++) begin
      mosi = i[0];
      #HALF;
      sck = 1;
      #HALF;
      sck = 0;
      check(miso === 1'b0, "R9 miso idle clocks", miso, 0);
    end
    peek_all("R11 idle clocks");
    rd_burst(0, 4, "R11 next txn");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule